// File: doc/BRIEF.md
# I2C Target Receive Engine

This block receives bytes as a target on a two-wire open-drain bus. It samples the clock and data lines through a two-flop synchronizer and detects START, STOP and clock edges on the synchronized values. It compares the first byte after a START against a fixed 7-bit address. On a match it records the read/write bit and returns an acknowledge. During a write transfer it reports each data byte on a one-cycle strobe.

A configuration write port sets three bits. The first chooses whether the ninth clock of a matched byte carries an ACK or a NACK. The second enables clock stretching. The third chooses whether the stretch starts after the eighth or the ninth falling clock edge. While the abort input is high, the acknowledge choice is forced to NACK. A release strobe ends a stretch, and bit counting then resumes. The block drives the bus only through two pull-low outputs.

Top module: `i2c_rx_target`

## Requirements
- R1: With the acknowledge choice at 0, the block pulls SDA low throughout the ninth clock of a matched address byte and of every data byte in a write transfer.
- R2: With the acknowledge choice at 1, SDA stays released in the ninth clock of those bytes.
- R3: The acknowledge choice changes only on a configuration write. While abort is high it reads 1 from the next cycle on, configuration writes to it are ignored, and it stays 1 after abort falls until software writes it.
- R4: With stretching enabled and the stretch point at 1, SCL is held low after the 8th falling edge of a matched byte until a release strobe.
- R5: With stretching enabled and the stretch point at 0, SCL is held low after the 9th falling edge of a matched byte until a release strobe.
- R6: With stretching disabled, SCL is never pulled low, whatever the stretch point is.
- R7: The direction output takes the LSB of a matched address byte (1 = read, 0 = write) at that byte's 8th falling edge. It changes at no other time and has no write path.
- R8: In a write transfer, data bits are taken MSB first on SCL rising edges. Each byte is presented on rx_data_o with a one-cycle rx_valid_o pulse after its 8th falling edge.
- R9: After an address mismatch, the block neither pulls a line nor reports a byte until the next START. After a matched read address, it acknowledges the address and then leaves SDA released and reports no bytes.
- R10: A STOP returns the block to idle with both pulls released. A START, including a repeated START in mid-byte, restarts bit counting so that the next byte is treated as an address.
- R11: The block asserts its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK) |
| cfg_we | input | 1 | Writes the three configuration bits |
| cfg_nack | input | 1 | Acknowledge choice: 1 = NACK, 0 = ACK |
| cfg_str_en | input | 1 | Clock stretching enable |
| cfg_str_at8 | input | 1 | Stretch point: 1 = after 8th fall, 0 = after 9th fall |
| abort_i | input | 1 | Abort level; forces NACK |
| release_i | input | 1 | One-cycle strobe that ends a stretch |
| nack_o | output | 1 | Current acknowledge choice |
| dir_o | output | 1 | Captured read/write bit of the last matched address |
| rx_valid_o | output | 1 | One-cycle strobe for a received data byte |
| rx_data_o | output | 8 | Received data byte |

## Verification
A line change at scl_i or sda_i reaches the pull outputs and rx_valid_o at the third rising clock edge after it: two synchronizer flops and one state register. nack_o follows abort_i or a configuration write one edge later. The bench moves the bus lines only every 25 clock cycles. It samples SDA in the middle of the ninth SCL-high phase, and the stretch output 25 cycles after a falling edge, so every sampled value has long settled. Received bytes are compared by a monitor whenever the strobe appears, so its exact cycle does not matter. Each strobe must match the next entry the driver queued, and the queue must be empty at the end.

// File: rtl/i2c_rx_target.sv
module i2c_rx_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  input  logic       cfg_we,
  input  logic       cfg_nack,
  input  logic       cfg_str_en,
  input  logic       cfg_str_at8,
  input  logic       abort_i,
  input  logic       release_i,
  output logic       nack_o,
  output logic       dir_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_SKIP} st_t;

  st_t        state_q;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q;
  logic       nack_q, str_en_q, str_at8_q, dir_q;
  logic       sda_pull_q, scl_pull_q, rx_valid_q;
  logic [7:0] rx_data_q;

  wire scl_s     = scl_q[1];
  wire scl_p     = scl_q[2];
  wire sda_s     = sda_q[1];
  wire sda_p     = sda_q[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire active    = (state_q == ST_ADDR) || (state_q == ST_WR);
  wire addr_hit  = (shreg_q[7:1] == TARGET_ADDR);
  wire addr_done = (state_q == ST_ADDR) && scl_fall && (cnt_q == 4'd8);

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign nack_o     = nack_q;
  assign dir_o      = dir_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_q    <= 1'b0;
      str_en_q  <= 1'b0;
      str_at8_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        str_en_q  <= cfg_str_en;
        str_at8_q <= cfg_str_at8;
      end
      if (abort_i)     nack_q <= 1'b1;
      else if (cfg_we) nack_q <= cfg_nack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= 4'd0;
      shreg_q    <= 8'd0;
      dir_q      <= 1'b0;
      sda_pull_q <= 1'b0;
      scl_pull_q <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= 8'd0;
    end else begin
      rx_valid_q <= 1'b0;
      if (release_i) scl_pull_q <= 1'b0;
      if (stop_det) begin
        state_q    <= ST_IDLE;
        cnt_q      <= 4'd0;
        sda_pull_q <= 1'b0;
        scl_pull_q <= 1'b0;
      end else if (start_det) begin
        state_q    <= ST_ADDR;
        cnt_q      <= 4'd0;
        sda_pull_q <= 1'b0;
        scl_pull_q <= 1'b0;
      end else if (active) begin
        if (scl_rise && cnt_q < 4'd8) begin
          shreg_q <= {shreg_q[6:0], sda_s};
          cnt_q   <= cnt_q + 4'd1;
        end else if (scl_rise) begin
          cnt_q <= 4'd9;
        end
        if (scl_fall && cnt_q == 4'd8) begin
          if (state_q == ST_ADDR && !addr_hit) begin
            state_q <= ST_SKIP;
          end else begin
            sda_pull_q <= ~nack_q;
            if (str_en_q && str_at8_q) scl_pull_q <= 1'b1;
            if (state_q == ST_ADDR) begin
              dir_q <= shreg_q[0];
            end else begin
              rx_valid_q <= 1'b1;
              rx_data_q  <= shreg_q;
            end
          end
        end
        if (scl_fall && cnt_q == 4'd9) begin
          cnt_q      <= 4'd0;
          sda_pull_q <= 1'b0;
          if (str_en_q && !str_at8_q) scl_pull_q <= 1'b1;
          if (state_q == ST_ADDR) state_q <= dir_q ? ST_SKIP : ST_WR;
        end
      end
    end
  end

  AST_ABORT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> nack_o); // R3
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o && !release_i && !start_det && !stop_det |=> scl_pull_o); // R4
  AST_NO_STRETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !str_en_q && !scl_pull_o |=> !scl_pull_o); // R6
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_done |=> $stable(dir_o)); // R7
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_pull_o && !rx_valid_o); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull_o && !scl_pull_o); // R10
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd9); // R10
  AST_SDA_PULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i); // R11

endmodule

// File: tb/test_i2c_rx_target.sv
module test_i2c_rx_target;
  localparam int H = 25;
  localparam logic [6:0] ADDR = 7'h42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic cfg_we = 1'b0, cfg_nack = 1'b0, cfg_str_en = 1'b0, cfg_str_at8 = 1'b0;
  logic abort_i = 1'b0, release_i = 1'b0;
  logic scl_pull_o, sda_pull_o, nack_o, dir_o, rx_valid_o;
  logic [7:0] rx_data_o;
  wire scl_line = scl_m & ~scl_pull_o;
  wire sda_line = sda_m & ~sda_pull_o;

  int vectors = 0, fails = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  i2c_rx_target #(.TARGET_ADDR(ADDR)) i_i2c_rx_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .cfg_we(cfg_we), .cfg_nack(cfg_nack), .cfg_str_en(cfg_str_en), .cfg_str_at8(cfg_str_at8),
    .abort_i(abort_i), .release_i(release_i),
    .nack_o(nack_o), .dir_o(dir_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit nk, input bit en, input bit at8);
    @(negedge clk);
    cfg_we = 1'b1; cfg_nack = nk; cfg_str_en = en; cfg_str_at8 = at8;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic release_stretch();
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(H);
    scl_high(); wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(H);
    scl_high(); wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic clk_bit(input bit b);
    sda_m = b; wt(H);
    scl_high(); wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic xfer(input logic [7:0] b, input bit ack, input bit s8, input bit s9, input string req);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    chk(scl_pull_o == s8, {req, " stretch after 8th fall"}, scl_pull_o, s8);
    if (s8) begin
      chk(scl_line == 1'b0, {req, " SCL held low"}, scl_line, 0);
      release_stretch();
    end
    sda_m = 1'b1; wt(H);
    scl_high(); wt(H / 2);
    chk(sda_line == !ack, {req, " ninth-clock SDA"}, sda_line, !ack);
    wt(H - H / 2);
    scl_m = 1'b0; wt(H);
    chk(scl_pull_o == s9, {req, " stretch after 9th fall"}, scl_pull_o, s9);
    if (s9) release_stretch();
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected byte", rx_data_o, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data_o == e, "R8 received byte", rx_data_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    chk(!scl_pull_o && !sda_pull_o, "R10 reset pulls", {scl_pull_o, sda_pull_o}, 0);
    chk(nack_o == 1'b0 && dir_o == 1'b0 && !rx_valid_o, "R3 reset state", {nack_o, dir_o, rx_valid_o}, 0);

    // R1 R8: ACK on address and data, two bytes MSB first
    cfg(1'b0, 1'b0, 1'b0);
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0, "R1 addr");
    exp_q.push_back(8'hA5); xfer(8'hA5, 1'b1, 1'b0, 1'b0, "R1 data");
    exp_q.push_back(8'h3C); xfer(8'h3C, 1'b1, 1'b0, 1'b0, "R8 data");
    do_stop();
    chk(!scl_pull_o && !sda_pull_o, "R10 released after STOP", {scl_pull_o, sda_pull_o}, 0);
    chk(dir_o == 1'b0, "R7 write direction", dir_o, 0);

    // R2: NACK
    cfg(1'b1, 1'b0, 1'b0);
    do_start();
    xfer({ADDR, 1'b0}, 1'b0, 1'b0, 1'b0, "R2 addr");
    exp_q.push_back(8'h5A); xfer(8'h5A, 1'b0, 1'b0, 1'b0, "R2 data");
    do_stop();

    // R3: abort forces NACK, writes ignored, value held
    cfg(1'b0, 1'b0, 1'b0);
    chk(nack_o == 1'b0, "R3 write ACK", nack_o, 0);
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk);
    chk(nack_o == 1'b1, "R3 abort forces NACK", nack_o, 1);
    cfg_we = 1'b1; cfg_nack = 1'b0;
    @(negedge clk); cfg_we = 1'b0;
    chk(nack_o == 1'b1, "R3 write ignored during abort", nack_o, 1);
    abort_i = 1'b0; wt(5);
    chk(nack_o == 1'b1, "R3 value held after abort", nack_o, 1);
    cfg(1'b0, 1'b0, 1'b0);
    chk(nack_o == 1'b0, "R3 write after abort", nack_o, 0);

    // R4: stretch after 8th fall
    cfg(1'b0, 1'b1, 1'b1);
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b1, 1'b0, "R4 addr");
    exp_q.push_back(8'h81); xfer(8'h81, 1'b1, 1'b1, 1'b0, "R4 data");
    do_stop();

    // R5: stretch after 9th fall
    cfg(1'b0, 1'b1, 1'b0);
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b0, 1'b1, "R5 addr");
    exp_q.push_back(8'h7E); xfer(8'h7E, 1'b1, 1'b0, 1'b1, "R5 data");
    do_stop();

    // R6: stretching disabled, stretch point ignored
    cfg(1'b0, 1'b0, 1'b1);
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0, "R6 addr");
    exp_q.push_back(8'hC3); xfer(8'hC3, 1'b1, 1'b0, 1'b0, "R6 data");
    do_stop();

    // R7 R9: matched read address, then no data reported
    cfg(1'b0, 1'b0, 1'b0);
    do_start();
    xfer({ADDR, 1'b1}, 1'b1, 1'b0, 1'b0, "R7 read addr");
    chk(dir_o == 1'b1, "R7 read direction", dir_o, 1);
    xfer(8'hFF, 1'b0, 1'b0, 1'b0, "R9 read byte");
    do_stop();

    // R9 R7: mismatched address
    do_start();
    xfer({ADDR ^ 7'h01, 1'b0}, 1'b0, 1'b0, 1'b0, "R9 mismatch addr");
    xfer(8'h12, 1'b0, 1'b0, 1'b0, "R9 mismatch data");
    chk(dir_o == 1'b1, "R7 direction kept on mismatch", dir_o, 1);
    do_stop();

    // R10: repeated START mid-byte
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0, "R10 addr");
    for (int i = 0; i < 4; i++) clk_bit(i[0]);
    do_start();
    xfer({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0, "R10 addr after restart");
    exp_q.push_back(8'h66); xfer(8'h66, 1'b1, 1'b0, 1'b0, "R10 data after restart");
    do_stop();
    chk(dir_o == 1'b0, "R7 direction after restart", dir_o, 0);

    wt(10);
    chk(exp_q.size() == 0, "R8 all bytes delivered", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule